// File: doc/BRIEF.md
# Indirect Byte-Window Access Bridge

This block lets a host with a four-byte bus window reach a much larger internal byte space. One window byte always holds a mode register. When indirect mode is on, two window bytes hold a 16-bit address pointer, loaded high byte first. The fourth byte is a data port that reads or writes the internal byte the pointer selects. With auto-increment on, the pointer steps by one after every data-port access. A host can then stream a whole buffer through a single port.

The internal space is a byte RAM behind a mode register at internal address zero. The lower half of a 32 KB region is the default. The transmit area (0x4000 to 0x5FFF) and the receive area (0x6000 to 0x7FFF) are ordinary addresses to the pointer. Moving from one to the other is a plain +1 step with no wrap at the area edge. With indirect mode off, window bytes 1 to 3 address internal bytes 1 to 3 directly. Host reads return one cycle after the access.

Top module: `ixb_bridge`

## Requirements
- R1: After reset the mode register reads 0x00, and the pointer reads 0x0000 once indirect mode is selected.
- R2: Window offset 0 reaches the mode register in both modes. Bits 6:0 read back as written. Bit 1 is auto-increment and bit 0 is indirect enable.
- R3: In indirect mode, offset 1 reads and writes pointer bits 15:8 and offset 2 reads and writes pointer bits 7:0.
- R4: In indirect mode, a write to offset 3 stores its byte at the internal address the pointer holds, and a read of offset 3 returns that byte.
- R5: With auto-increment set, every read or write of offset 3 adds one to the pointer after the access, so two successive reads return a big-endian 16-bit value.
- R6: With auto-increment clear, a data-port access leaves the pointer unchanged.
- R7: An incrementing pointer passes from 0x5FFF to 0x6000 without wrapping to the start of either buffer area.
- R8: An increment from 0xFFFF gives 0x0000.
- R9: Writing the mode register with bit 7 set clears every mode bit and the pointer in the next cycle. Bit 7 always reads 0, and RAM contents are kept.
- R10: With indirect mode clear, offsets 1, 2 and 3 read and write internal addresses 1, 2 and 3, and the pointer does not change.
- R11: Internal address 0x0000, reached through the data port, is the mode register for both reads and writes.
- R12: Internal addresses at or above 0x8000 read as 0x00, and writes to them are ignored.
- R13: Read data and a one-cycle valid flag appear in the cycle after a read access, and the valid flag is low after every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Window access strobe, one access per cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Window byte offset |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, registered |
| host_rvalid | output | 1 | High for one cycle when host_rdata holds a read result |

## Verification
A wrong pointer shows up as data taken from the wrong location, or as a pointer that reads back wrong on offsets 1 and 2. The bench reads the pointer back after each stream of accesses, so a missing or extra step is seen before the next access pattern starts. Mode corruption changes how offsets 1 to 3 decode, and the next window read shows it. A bad soft reset leaves stale pointer bytes that are visible one access later. Every read result is checked in the cycle after its access.

// File: rtl/ixb_pkg.sv
package ixb_pkg;
   localparam int WIN_AW = 2;
   localparam int BYTE_W = 8;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [WIN_AW-1:0] {
      OFS_MODE   = 2'd0,
      OFS_PTR_HI = 2'd1,
      OFS_PTR_LO = 2'd2,
      OFS_DATA   = 2'd3
   } ixb_ofs_e;

   localparam int MODE_SRST = 7;
   localparam int MODE_AINC = 1;
   localparam int MODE_IND  = 0;
endpackage

// File: rtl/ixb_mode_reg.sv
module ixb_mode_reg
   import ixb_pkg::*;
#(
   parameter byte_t KEEP_MASK = 8'h7F
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  byte_t wdata,
   output byte_t mode_q,
   output logic  srst
);
   generate
      if (KEEP_MASK[MODE_SRST] != 1'b0) begin : g_bad_mask
         $error("ixb_mode_reg: the reset bit must not be stored");
      end
   endgenerate

   byte_t mode_r;

   assign srst   = wr_en && wdata[MODE_SRST];
   assign mode_q = mode_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_r <= '0;
      end else if (srst) begin
         mode_r <= '0;
      end else if (wr_en) begin
         mode_r <= wdata & KEEP_MASK;
      end
   end
endmodule

// File: rtl/ixb_pointer.sv
module ixb_pointer
   import ixb_pkg::*;
#(
   parameter int PTR_W = 16,
   localparam int NB   = PTR_W / BYTE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [NB-1:0]    lane_we,
   input  byte_t            wdata,
   input  logic             step,
   output logic [PTR_W-1:0] ptr_q
);
   generate
      if (PTR_W % BYTE_W != 0 || NB < 1) begin : g_bad_w
         $error("ixb_pointer: width must be a whole number of bytes");
      end
   endgenerate

   logic [PTR_W-1:0] ptr_nxt;
   assign ptr_nxt = ptr_q + PTR_W'(1);

   for (genvar i = 0; i < NB; i++) begin : g_lane
      byte_t q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (clr) begin
            q <= '0;
         end else if (lane_we[i]) begin
            q <= wdata;
         end else if (step) begin
            q <= ptr_nxt[i*BYTE_W +: BYTE_W];
         end
      end
      assign ptr_q[i*BYTE_W +: BYTE_W] = q;
   end
endmodule

// File: rtl/ixb_store.sv
module ixb_store
   import ixb_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int SPACE_AW = 15,
   parameter int MEM_AW   = 11,
   localparam int DEPTH   = 1 << MEM_AW
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  byte_t             wdata,
   output byte_t             rdata
);
   generate
      if (MEM_AW > SPACE_AW || SPACE_AW > ADDR_W) begin : g_bad_geom
         $error("ixb_store: need MEM_AW <= SPACE_AW <= ADDR_W");
      end
   endgenerate

   logic hit;

   generate
      if (SPACE_AW == ADDR_W) begin : g_full_map
         assign hit = 1'b1;
      end else begin : g_part_map
         assign hit = (addr[ADDR_W-1:SPACE_AW] == '0);
      end
   endgenerate

   byte_t             mem [DEPTH];
   logic [MEM_AW-1:0] idx;

   assign idx   = addr[MEM_AW-1:0];
   assign rdata = hit ? mem[idx] : '0;

   always_ff @(posedge clk) begin
      if (wr_en && hit) begin
         mem[idx] <= wdata;
      end
   end
endmodule

// File: rtl/ixb_bridge.sv
module ixb_bridge
   import ixb_pkg::*;
#(
   parameter int PTR_W    = 16,
   parameter int SPACE_AW = 15,
   parameter int MEM_AW   = 11,
   localparam int NB      = PTR_W / BYTE_W
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_sel,
   input  logic       host_wr,
   input  logic [1:0] host_addr,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   output logic       host_rvalid
);
   generate
      if (NB != 2) begin : g_bad_ptr
         $error("ixb_bridge: the window holds exactly two pointer bytes");
      end
   endgenerate

   ixb_ofs_e         ofs;
   byte_t            mode_q;
   logic [PTR_W-1:0] ptr_q;
   logic             srst;
   logic             ind, ainc;
   logic             int_sel, int_is_mode;
   logic [PTR_W-1:0] int_addr;
   logic             mode_wr;
   logic [NB-1:0]    lane_we;
   logic             step;
   byte_t            store_rdata, int_rd, rd_next;
   byte_t            rdata_q;
   logic             rvalid_q;

   assign ofs  = ixb_ofs_e'(host_addr);
   assign ind  = mode_q[MODE_IND];
   assign ainc = mode_q[MODE_AINC];

   // internal target: pointer in indirect mode, window offset otherwise
   assign int_sel     = host_sel && (ind ? (ofs == OFS_DATA) : (ofs != OFS_MODE));
   assign int_addr    = ind ? ptr_q : PTR_W'(host_addr);
   assign int_is_mode = (int_addr == '0);

   assign mode_wr = host_sel && host_wr &&
                    ((ofs == OFS_MODE) || (int_sel && int_is_mode));

   assign lane_we[NB-1] = host_sel && host_wr && ind && (ofs == OFS_PTR_HI);
   assign lane_we[NB-2] = host_sel && host_wr && ind && (ofs == OFS_PTR_LO);
   assign step          = host_sel && ind && ainc && (ofs == OFS_DATA);

   ixb_mode_reg #(.KEEP_MASK(8'h7F)) u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (mode_wr),
      .wdata  (host_wdata),
      .mode_q (mode_q),
      .srst   (srst)
   );

   ixb_pointer #(.PTR_W(PTR_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (srst),
      .lane_we (lane_we),
      .wdata   (host_wdata),
      .step    (step),
      .ptr_q   (ptr_q)
   );

   ixb_store #(.ADDR_W(PTR_W), .SPACE_AW(SPACE_AW), .MEM_AW(MEM_AW)) u_store (
      .clk   (clk),
      .wr_en (int_sel && host_wr && !int_is_mode),
      .addr  (int_addr),
      .wdata (host_wdata),
      .rdata (store_rdata)
   );

   assign int_rd = int_is_mode ? mode_q : store_rdata;

   always_comb begin
      unique case (ofs)
         OFS_MODE:   rd_next = mode_q;
         OFS_PTR_HI: rd_next = ind ? ptr_q[PTR_W-1 -: BYTE_W] : int_rd;
         OFS_PTR_LO: rd_next = ind ? ptr_q[BYTE_W-1:0] : int_rd;
         default:    rd_next = int_rd;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= host_sel && !host_wr;
         if (host_sel && !host_wr) begin
            rdata_q <= rd_next;
         end
      end
   end

   assign host_rdata  = rdata_q;
   assign host_rvalid = rvalid_q;
endmodule

// File: rtl/ixb_bridge_chk.sv
module ixb_bridge_chk #(
   parameter int PTR_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_sel,
   input logic             host_wr,
   input logic [1:0]       host_addr,
   input logic [7:0]       host_wdata,
   input logic             host_rvalid,
   input logic [7:0]       mode_q,
   input logic [PTR_W-1:0] ptr_q
);
   logic rd_acc, srst_host, srst_port;
   assign rd_acc    = host_sel && !host_wr;
   assign srst_host = host_sel && host_wr && host_addr == 2'd0 && host_wdata[7];
   assign srst_port = host_sel && host_wr && host_addr == 2'd3 && mode_q[0] &&
                      ptr_q == '0 && host_wdata[7];

   p_rdlat_r13: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc |=> host_rvalid);
   p_noread_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_acc |=> !host_rvalid);
   p_srst_r9: assert property (@(posedge clk) disable iff (!rst_n)
      srst_host |=> (mode_q == 8'h00 && ptr_q == '0));
   p_ptrhi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && host_wr && host_addr == 2'd1 && mode_q[0])
      |=> ptr_q[PTR_W-1 -: 8] == $past(host_wdata));
   p_ptrlo_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && host_wr && host_addr == 2'd2 && mode_q[0])
      |=> ptr_q[7:0] == $past(host_wdata));
   p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && host_addr == 2'd3 && mode_q[0] && mode_q[1] && !srst_port)
      |=> ptr_q == PTR_W'($past(ptr_q) + PTR_W'(1)));
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && host_addr == 2'd3 && mode_q[0] && !mode_q[1] && !srst_port)
      |=> $stable(ptr_q));
   p_direct_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && !mode_q[0] && !srst_host) |=> $stable(ptr_q));
   p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !host_sel |=> $stable(ptr_q));
endmodule

bind ixb_bridge ixb_bridge_chk #(.PTR_W(PTR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_sel    (host_sel),
   .host_wr     (host_wr),
   .host_addr   (host_addr),
   .host_wdata  (host_wdata),
   .host_rvalid (host_rvalid),
   .mode_q      (mode_q),
   .ptr_q       (ptr_q)
);

// File: tb/ixb_bridge_tb.sv
module ixb_bridge_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_sel = 1'b0;
   logic       host_wr = 1'b0;
   logic [1:0] host_addr = 2'd0;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;
   logic       host_rvalid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ixb_bridge u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_sel    (host_sel),
      .host_wr     (host_wr),
      .host_addr   (host_addr),
      .host_wdata  (host_wdata),
      .host_rdata  (host_rdata),
      .host_rvalid (host_rvalid)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_sel = 1'b0; host_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d, output logic v);
      @(negedge clk);
      host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
      @(negedge clk);
      d = host_rdata; v = host_rvalid;
      host_sel = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
      logic [7:0] d;
      logic       v;
      rd(a, d, v);
      chk({tag, " valid"}, {7'd0, v}, 8'h01);
      chk(tag, d, exp);
   endtask

   task automatic set_ptr(input logic [15:0] p);
      wr(2'd1, p[15:8]);
      wr(2'd2, p[7:0]);
   endtask

   task automatic ptr_chk(input string tag, input logic [15:0] exp);
      rd_chk({tag, " ptr hi"}, 2'd1, exp[15:8]);
      rd_chk({tag, " ptr lo"}, 2'd2, exp[7:0]);
   endtask

   task automatic t_reset;
      rd_chk("R1 mode after reset", 2'd0, 8'h00);
      @(negedge clk);
      chk("R13 valid low when idle", {7'd0, host_rvalid}, 8'h00);
      wr(2'd0, 8'h01);
      ptr_chk("R1", 16'h0000);
   endtask

   task automatic t_mode;
      wr(2'd0, 8'h7C);
      rd_chk("R2 mode bits 6:0 readback", 2'd0, 8'h7C);
      wr(2'd0, 8'h00);
      rd_chk("R2 mode cleared", 2'd0, 8'h00);
   endtask

   task automatic t_pointer;
      wr(2'd0, 8'h01);
      set_ptr(16'h1234);
      ptr_chk("R3 big-endian pointer", 16'h1234);
   endtask

   task automatic t_data;
      wr(2'd0, 8'h01);
      set_ptr(16'h4010);
      wr(2'd3, 8'hA5);
      rd_chk("R4 data port readback", 2'd3, 8'hA5);
      ptr_chk("R6 pointer held", 16'h4010);
   endtask

   task automatic t_autoinc;
      wr(2'd0, 8'h03);
      set_ptr(16'h4100);
      wr(2'd3, 8'hBE);
      wr(2'd3, 8'hEF);
      ptr_chk("R5 after two writes", 16'h4102);
      set_ptr(16'h4100);
      rd_chk("R5 first byte", 2'd3, 8'hBE);
      rd_chk("R5 second byte", 2'd3, 8'hEF);
      ptr_chk("R5 after two reads", 16'h4102);
   endtask

   task automatic t_boundary;
      wr(2'd0, 8'h03);
      set_ptr(16'h5FFE);
      wr(2'd3, 8'h01);
      wr(2'd3, 8'h02);
      wr(2'd3, 8'h03);
      ptr_chk("R7 no area wrap", 16'h6001);
      set_ptr(16'h5FFF);
      rd_chk("R7 byte at 5FFF", 2'd3, 8'h02);
      rd_chk("R7 byte at 6000", 2'd3, 8'h03);
   endtask

   task automatic t_wrap;
      wr(2'd0, 8'h03);
      set_ptr(16'hFFFF);
      rd_chk("R12 high address reads zero", 2'd3, 8'h00);
      ptr_chk("R8 wrap to zero", 16'h0000);
   endtask

   task automatic t_high;
      wr(2'd0, 8'h01);
      set_ptr(16'h0123);
      wr(2'd3, 8'h11);
      set_ptr(16'h8123);
      wr(2'd3, 8'h77);
      rd_chk("R12 high write not stored", 2'd3, 8'h00);
      set_ptr(16'h0123);
      rd_chk("R12 low byte untouched", 2'd3, 8'h11);
   endtask

   task automatic t_mode_port;
      wr(2'd0, 8'h03);
      set_ptr(16'h0000);
      rd_chk("R11 mode via data port", 2'd3, 8'h03);
      set_ptr(16'h0000);
      wr(2'd3, 8'h01);
      rd_chk("R11 mode written via data port", 2'd0, 8'h01);
   endtask

   task automatic t_direct;
      wr(2'd0, 8'h01);
      set_ptr(16'h0777);
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h91);
      wr(2'd2, 8'h92);
      wr(2'd3, 8'h93);
      rd_chk("R10 direct addr 1", 2'd1, 8'h91);
      rd_chk("R10 direct addr 2", 2'd2, 8'h92);
      rd_chk("R10 direct addr 3", 2'd3, 8'h93);
      wr(2'd0, 8'h01);
      ptr_chk("R10 pointer untouched", 16'h0777);
      set_ptr(16'h0001);
      rd_chk("R10 same location indirect", 2'd3, 8'h91);
   endtask

   task automatic t_srst;
      wr(2'd0, 8'h01);
      set_ptr(16'h4444);
      wr(2'd3, 8'h5A);
      wr(2'd0, 8'h83);
      rd_chk("R9 mode cleared, bit7 reads 0", 2'd0, 8'h00);
      wr(2'd0, 8'h01);
      ptr_chk("R9 pointer cleared", 16'h0000);
      set_ptr(16'h4444);
      rd_chk("R9 RAM kept", 2'd3, 8'h5A);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mode();
      t_pointer();
      t_data();
      t_autoinc();
      t_boundary();
      t_wrap();
      t_high();
      t_mode_port();
      t_direct();
      t_srst();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule